// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes, which has a 19-bit address, an 8-bit bidirectional data bus and three active-low strobes: chip select, output enable and write enable. The host asks for a single-word read or write with a request/ready handshake. The controller then produces a strobe sequence that meets the memory's AC timing and returns read data with a one-cycle valid pulse.

Every timing margin is a parameter measured in clock cycles. Each margin is derived at elaboration from the clock period and the memory's nanosecond speed grade (70, 85, 100 or 120). Any other grade value is given the slowest grade's margins. The data bus is split into an output value, an output enable for the pad driver and an input value. The pad itself sits outside this block.

The sequencer has five states. IDLE waits with `ready` high. RD_ACCESS holds chip select and output enable low until the read data is valid, and captures the data on its last cycle. RD_TURN releases all strobes and waits out the memory's output-disable time. WR_PULSE holds chip select and write enable low and drives the write data. WR_HOLD releases the strobes, keeps the address and data stable, and pads the write to a full write cycle. The transitions are as follows:
- IDLE moves to RD_ACCESS or WR_PULSE when a request is accepted.
- RD_ACCESS moves to RD_TURN after the read-strobe count.
- RD_TURN moves to IDLE after the turnaround count.
- WR_PULSE moves to WR_HOLD after the write-pulse count.
- WR_HOLD moves to IDLE after the hold count.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and straight after reset, `ready` is 1, all three strobes are 1, `sram_dq_oe` is 0 and `rvalid` is 0.
- R2: Each margin is ceil(ns / CLK_PERIOD_NS), with a minimum of 1 cycle. The margins are: read strobe = max(cycle time, output-enable access); turnaround = output-disable time; write pulse = max(pulse width, address-to-end, data-to-end); hold = max(5 ns address hold, write cycle minus write pulse). With a 4 ns clock and the 70 ns grade, these are 18, 7, 15 and 3 cycles.
- R3: A read holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly the read-strobe count, with the bus driver off.
- R4: Read data is sampled from `sram_dq_in` on the last read-strobe edge. `rdata` changes only then, and `rvalid` is high for exactly one cycle, in the cycle after output enable rises.
- R5: A write holds `sram_we_n`=0 and `sram_cs_n`=0 for exactly the write-pulse count, with `sram_oe_n`=1, `sram_dq_oe`=1 and `sram_dq_out` equal to the accepted write data.
- R6: Write enable and output enable are never low together.
- R7: The bus driver is never on while output enable is low. After output enable rises, the driver stays off for at least the turnaround count.
- R8: `ready` falls in the cycle after acceptance. It stays low for read strobe + turnaround cycles on a read (25 by default) and write pulse + hold cycles on a write (18 by default).
- R9: `sram_addr` holds the accepted address and does not change while `ready` is low.
- R10: A request raised while `ready` is low and dropped before `ready` returns has no effect on the memory and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host request; accepted when `ready` is also high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | Controller idle and able to accept a request |
| rdata | output | DATA_W | Last captured read data |
| rvalid | output | 1 | One-cycle pulse when `rdata` updates |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_out | output | DATA_W | Value for the data-bus pad driver |
| sram_dq_oe | output | 1 | Data-bus pad driver enable |
| sram_dq_in | input | DATA_W | Value read back from the data-bus pad |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |

## Verification
The bound checker enforces the following properties on every cycle:
- Write enable and output enable are never low together.
- The driver is never on during a read, and it waits out the turnaround gap after a read.
- Exact read-strobe and write-strobe lengths are measured with counters.
- The read-valid pulse is a single cycle and follows a read.
- The address is stable while the controller is busy.

Some behaviour can only be shown by the bench's scenarios against its memory model: correct data values round-tripping through writes and reads, the exact busy length of each operation, the measured gap when a write waits behind a read, and a request dropped during a busy period leaving the memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } sram_state_e;

    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // output enable to valid data
    function automatic int oe_access_ns(input int grade);
        case (grade)
            70:      return 35;
            85:      return 40;
            100:     return 50;
            default: return 60;
        endcase
    endfunction

    // strobe release to bus high-Z
    function automatic int release_hz_ns(input int grade);
        return (grade == 70 || grade == 85) ? 25 : 35;
    endfunction

    function automatic int we_width_ns(input int grade);
        return (grade == 70 || grade == 85) ? 50 : 60;
    endfunction

    // address valid (and chip select) to end of write
    function automatic int addr_to_end_ns(input int grade);
        case (grade)
            70:      return 60;
            85:      return 75;
            100:     return 80;
            default: return 100;
        endcase
    endfunction

    function automatic int data_to_end_ns(input int grade);
        return (grade == 70 || grade == 85) ? 30 : 40;
    endfunction

    function automatic int cycle_ns(input int grade);
        case (grade)
            70, 85, 100: return grade;
            default:     return 120;
        endcase
    endfunction

    function automatic int rd_strobe_cycles(input int grade, input int period);
        return imax(ns_to_cyc(cycle_ns(grade), period),
                    ns_to_cyc(oe_access_ns(grade), period));
    endfunction

    function automatic int turn_cycles(input int grade, input int period);
        return ns_to_cyc(release_hz_ns(grade), period);
    endfunction

    function automatic int wr_pulse_cycles(input int grade, input int period);
        return imax(ns_to_cyc(we_width_ns(grade), period),
                    imax(ns_to_cyc(addr_to_end_ns(grade), period),
                         ns_to_cyc(data_to_end_ns(grade), period)));
    endfunction

    function automatic int wr_hold_cycles(input int grade, input int period);
        return imax(ns_to_cyc(5, period),
                    ns_to_cyc(cycle_ns(grade), period) - wr_pulse_cycles(grade, period));
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC   = 18,
    parameter int TURN_CYC = 7,
    parameter int WP_CYC   = 15,
    parameter int HOLD_CYC = 3,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [CNT_W-1:0] cnt,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             timer_clr,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LAST   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    sram_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = wr ? ST_WR_PULSE : ST_RD_ACCESS;
                end
            end
            ST_RD_ACCESS: if (cnt == RD_LAST)   state_d = ST_RD_TURN;
            ST_RD_TURN:   if (cnt == TURN_LAST) state_d = ST_IDLE;
            ST_WR_PULSE:  if (cnt == WP_LAST)   state_d = ST_WR_HOLD;
            ST_WR_HOLD:   if (cnt == HOLD_LAST) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready     = 1'b0;
        capture   = 1'b0;
        cs_n      = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        dq_oe     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
            end
            ST_RD_ACCESS: begin
                cs_n    = 1'b0;
                oe_n    = 1'b0;
                capture = (cnt == RD_LAST);
            end
            ST_RD_TURN: begin
                // all strobes released; bus left to the memory to float
            end
            ST_WR_PULSE: begin
                cs_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                dq_oe = 1'b1;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
        accept    = ready && req;
        timer_clr = (state_d != state_q) || (state_q == ST_IDLE);
    end

endmodule

// File: rtl/sram_req_path.sv
module sram_req_path #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) begin
                rdata_q <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int SPEED_NS      = 70,
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);

    localparam int RD_CYC   = rd_strobe_cycles(SPEED_NS, CLK_PERIOD_NS);
    localparam int TURN_CYC = turn_cycles(SPEED_NS, CLK_PERIOD_NS);
    localparam int WP_CYC   = wr_pulse_cycles(SPEED_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC = wr_hold_cycles(SPEED_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC), imax(WP_CYC, HOLD_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             accept;
    logic             capture;
    logic             timer_clr;
    logic [CNT_W-1:0] cnt;

    sram_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .cnt   (cnt)
    );

    sram_seq_fsm #(
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .wr        (wr),
        .cnt       (cnt),
        .ready     (ready),
        .accept    (accept),
        .capture   (capture),
        .timer_clr (timer_clr),
        .cs_n      (sram_cs_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .dq_oe     (sram_dq_oe)
    );

    sram_req_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .capture  (capture),
        .addr_in  (addr),
        .wdata_in (wdata),
        .dq_in    (sram_dq_in),
        .addr_q   (sram_addr),
        .wdata_q  (sram_dq_out),
        .rdata_q  (rdata),
        .rvalid_q (rvalid)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int SPEED_NS      = 70,
    parameter int ADDR_W        = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              rvalid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_dq_oe,
    input logic              sram_cs_n,
    input logic              sram_oe_n,
    input logic              sram_we_n
);

    localparam int RD_CYC   = rd_strobe_cycles(SPEED_NS, CLK_PERIOD_NS);
    localparam int TURN_CYC = turn_cycles(SPEED_NS, CLK_PERIOD_NS);
    localparam int WP_CYC   = wr_pulse_cycles(SPEED_NS, CLK_PERIOD_NS);

    logic [15:0] oe_run, we_run, gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_run <= '0;
            we_run <= '0;
            gap    <= 16'hFFFF;
        end else begin
            oe_run <= !sram_oe_n ? oe_run + 16'd1 : 16'd0;
            we_run <= !sram_we_n ? we_run + 16'd1 : 16'd0;
            if (!sram_oe_n)        gap <= '0;
            else if (gap != 16'hFFFF) gap <= gap + 16'd1;
        end
    end

    a_r3_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_cs_n && sram_we_n));

    a_r3_read_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_run == 16'(RD_CYC)));

    a_r4_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    a_r4_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ($past(!sram_oe_n) && sram_oe_n));

    a_r5_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs_n && sram_dq_oe));

    a_r5_write_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_run == 16'(WP_CYC)));

    a_r6_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    a_r7_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (gap >= 16'(TURN_CYC)));

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(sram_addr));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .SPEED_NS      (SPEED_NS),
    .ADDR_W        (ADDR_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .ready      (ready),
    .rvalid     (rvalid),
    .sram_addr  (sram_addr),
    .sram_dq_oe (sram_dq_oe),
    .sram_cs_n  (sram_cs_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

    // 4 ns clock, 70 ns grade, worked by hand:
    // read strobe ceil(70/4)=18, turnaround ceil(25/4)=7,
    // write pulse max(ceil(50/4),ceil(60/4),ceil(30/4))=15, write cycle 18
    localparam int EXP_RD   = 18;
    localparam int EXP_TURN = 7;
    localparam int EXP_WP   = 15;
    localparam int EXP_RBUSY = 25;
    localparam int EXP_WBUSY = 18;

    typedef struct packed {
        logic        wr;
        logic [18:0] addr;
        logic [7:0]  wd;
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 19'h00000, 8'hA5, 8'h00},
        '{1'b1, 19'h7FF3C, 8'h3C, 8'h00},
        '{1'b1, 19'h12345, 8'h5A, 8'h00},
        '{1'b0, 19'h00000, 8'h00, 8'hA5},
        '{1'b0, 19'h7FF3C, 8'h00, 8'h3C},
        '{1'b1, 19'h12345, 8'hFF, 8'h00},
        '{1'b0, 19'h12345, 8'h00, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, rvalid, sram_dq_oe, sram_cs_n, sram_oe_n, sram_we_n;
    logic [7:0]  rdata, sram_dq_out, sram_dq_in;
    logic [18:0] sram_addr;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sram_async_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .wr          (wr),
        .addr        (addr),
        .wdata       (wdata),
        .ready       (ready),
        .rdata       (rdata),
        .rvalid      (rvalid),
        .sram_addr   (sram_addr),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe),
        .sram_dq_in  (sram_dq_in),
        .sram_cs_n   (sram_cs_n),
        .sram_oe_n   (sram_oe_n),
        .sram_we_n   (sram_we_n)
    );

    // memory model, indexed by the low address byte
    logic [7:0] mem [256];
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    end
    always @(posedge clk) begin
        if (!sram_cs_n && !sram_we_n && sram_dq_oe) mem[sram_addr[7:0]] <= sram_dq_out;
    end
    assign sram_dq_in = (!sram_cs_n && !sram_oe_n) ? mem[sram_addr[7:0]] : 8'h00;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic run_op(input logic w, input logic [18:0] a, input logic [7:0] d,
                          output int busy, output int we_lo, output int oe_lo,
                          output int rv, output logic [7:0] rd,
                          output int dq_bad, output int addr_bad);
        busy = 0; we_lo = 0; oe_lo = 0; rv = 0; rd = 8'h00; dq_bad = 0; addr_bad = 0;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        while (!ready) begin
            busy++;
            if (!sram_we_n) begin
                we_lo++;
                if (!sram_dq_oe || sram_dq_out != d) dq_bad++;
            end
            if (!sram_oe_n) oe_lo++;
            if (sram_addr != a) addr_bad++;
            if (rvalid) begin
                rv++;
                rd = rdata;
            end
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int busy, we_lo, oe_lo, rv, dq_bad, addr_bad;
        logic [7:0] rd;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready && sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rvalid,
            "R1 reset", {ready, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, rvalid}, 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rvalid,
            "R1 after reset", {ready, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, rvalid}, 6'b111100);

        // vector table
        for (int v = 0; v < 7; v++) begin
            run_op(VECS[v].wr, VECS[v].addr, VECS[v].wd, busy, we_lo, oe_lo, rv, rd, dq_bad, addr_bad);
            chk(addr_bad == 0, "R9 address held", addr_bad, 0);
            if (VECS[v].wr) begin
                chk(we_lo == EXP_WP, "R2 R5 write pulse", we_lo, EXP_WP);
                chk(dq_bad == 0 && oe_lo == 0, "R5 write data and OE high", dq_bad + oe_lo, 0);
                chk(busy == EXP_WBUSY, "R8 write busy", busy, EXP_WBUSY);
            end else begin
                chk(oe_lo == EXP_RD && we_lo == 0, "R2 R3 read strobe", oe_lo, EXP_RD);
                chk(rv == 1, "R4 single valid", rv, 1);
                chk(rd == VECS[v].exp, "R4 read data", rd, VECS[v].exp);
                chk(busy == EXP_RBUSY, "R8 read busy", busy, EXP_RBUSY);
            end
        end

        // R4: rdata holds its value with no capture
        repeat (4) @(negedge clk);
        chk(rdata == 8'hFF && !rvalid, "R4 rdata held", rdata, 8'hFF);

        // R7: write waits behind read, request held throughout
        begin
            int gap;
            bit seen_oe;
            gap = 0; seen_oe = 0;
            @(negedge clk);
            req = 1'b1; wr = 1'b0; addr = 19'h00050; wdata = 8'h00;
            @(negedge clk);
            wr = 1'b1; wdata = 8'h66;
            while (!sram_dq_oe) begin
                if (!sram_oe_n) seen_oe = 1;
                else if (seen_oe) gap++;
                if (sram_dq_oe === 1'b0 && !sram_oe_n && sram_dq_oe) gap = -100;
                @(negedge clk);
            end
            req = 1'b0;
            chk(gap == EXP_TURN + 1, "R7 turnaround gap", gap, EXP_TURN + 1);
            while (!ready) @(negedge clk);
        end

        // R10: a request pulsed while busy is dropped
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 19'h00020; wdata = 8'h11;
        @(negedge clk);
        req = 1'b0;
        repeat (5) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 19'h00030; wdata = 8'h77;
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(sram_cs_n && ready, "R10 no new cycle", {sram_cs_n, ready}, 2'b11);
        run_op(1'b0, 19'h00030, 8'h00, busy, we_lo, oe_lo, rv, rd, dq_bad, addr_bad);
        chk(rd == 8'h00, "R10 memory untouched", rd, 8'h00);
        run_op(1'b0, 19'h00020, 8'h00, busy, we_lo, oe_lo, rv, rd, dq_bad, addr_bad);
        chk(rd == 8'h11, "R5 accepted write landed", rd, 8'h11);
        run_op(1'b0, 19'h00050, 8'h00, busy, we_lo, oe_lo, rv, rd, dq_bad, addr_bad);
        chk(rd == 8'h66, "R7 queued write landed", rd, 8'h66);

        // R1: reset in the middle of a read
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 19'h00020;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ready && sram_cs_n && sram_oe_n && !sram_dq_oe && !rvalid,
            "R1 mid-cycle reset", {ready, sram_cs_n, sram_oe_n, sram_dq_oe, rvalid}, 5'b11100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule